// File: doc/BRIEF.md
# Secure fast-interrupt source splitter

This block sits between 32 level interrupt sources and a downstream non-secure interrupt controller. Software picks which sources belong to the secure world. A picked source is removed from the 32 pass-through outputs, so the non-secure controller never sees it. It can instead raise a single active-low fast interrupt (FIQ) towards the processor, once that source is also enabled. Unpicked sources reach the outputs unchanged and without delay.

The FIQ output merges three things: the enabled secure sources, an active-low secure FIQ coming from a chained upstream copy of this block (tied high when nothing is chained), and the active-low FIQ of the non-secure controller. A bypass bit can hand the output over to the non-secure FIQ alone. Software reaches the registers over an APB-style slave port. That port carries a privilege flag, which an access-protection bit can use to refuse unprivileged accesses. A key-based write lock freezes every register except the lock itself.

Top module: `secure_fiq_ctrl`

## Requirements
- R1: After reset every register reads zero: nothing is selected, enabled or bypassed, the block is unprotected and unlocked, and `irq_o` equals `src_i`.
- R2: `irq_o[i]` is `src_i[i]` when select bit i is 0 and is 0 when select bit i is 1. The path is combinational in `src_i`.
- R3: Offset 0x000 reads `src_i & select & enable` and offset 0x004 reads `src_i`. Both are read only.
- R4: The select register (0x008) and the enable register (0x00C) are read/write. A write shows in the register on the clock edge that ends the access phase.
- R5: Writing the enable-clear register (0x010) clears every enable bit whose data bit is 1 and leaves the bits whose data bit is 0. The register reads 0.
- R6: With bypass clear, `fiq_n_o` is low when any bit of the 0x000 value is 1, or `chain_fiq_n_i` is low, or `nsfiq_n_i` is low. Otherwise it is high.
- R7: The bypass register (0x014) keeps only data bit 0 and reads back `{31'b0, bit0}`. While that bit is 1, `fiq_n_o` equals `nsfiq_n_i`.
- R8: The protection register (0x018) keeps data bit 0. While it is 1, any access with `ppriv` = 0 is ignored: the write changes nothing and the read returns 0. Accesses with `ppriv` = 1 work as usual.
- R9: Writing 0x0ACCE550 to the lock register (0x01C) unlocks the block, and writing any other value locks it. Offset 0x020 reads 1 when locked and 0 when unlocked. 0x01C reads 0.
- R10: While locked, writes to offsets 0x008 through 0x018 are ignored, reads still return data, and the lock register stays writable.
- R11: Addresses from 0x024 upward, and writes to the read-only offsets, change no register. Such addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address; bits [1:0] are ignored |
| pwdata | input | 32 | Write data |
| ppriv | input | 1 | 1 = privileged access, 0 = user access |
| prdata | output | 32 | Read data, valid while psel is high and pwrite is low |
| src_i | input | 32 | Interrupt source levels, active high |
| nsfiq_n_i | input | 1 | Non-secure controller FIQ, active low |
| chain_fiq_n_i | input | 1 | Secure FIQ from a chained controller, active low |
| irq_o | output | 32 | Sources passed on to the non-secure controller |
| fiq_n_o | output | 1 | FIQ to the processor, active low |

## Verification
The assertions assume that the bus follows the two-phase pattern: a setup cycle with `penable` low, then one access cycle with `psel`, `pwrite`, `paddr` and `pwdata` held steady. They also assume that `ppriv` is stable through the transfer. The bench drives every transfer through one write task and one read task, which change the bus only on the falling clock edge and always issue setup then access. The source, chain and non-secure FIQ levels also change only on the falling edge, so the combinational outputs have settled before they are compared.

// File: rtl/sfiq_pkg.sv
package sfiq_pkg;

    parameter int unsigned DATA_W = 32;
    parameter int unsigned SRC_N  = 32;
    parameter int unsigned REG_COUNT = 9;
    parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'h0ACC_E550;

    typedef enum logic [3:0] {
        RG_FIQSTAT = 4'd0,
        RG_RAW     = 4'd1,
        RG_SEL     = 4'd2,
        RG_EN      = 4'd3,
        RG_ENCLR   = 4'd4,
        RG_BYP     = 4'd5,
        RG_PROT    = 4'd6,
        RG_LOCK    = 4'd7,
        RG_LOCKST  = 4'd8,
        RG_NONE    = 4'd15
    } reg_id_e;

    typedef struct packed {
        logic [SRC_N-1:0] sel;
        logic [SRC_N-1:0] en;
        logic             byp;
        logic             prot;
        logic             lock;
    } cfg_t;

endpackage

// File: rtl/sfiq_decode.sv
module sfiq_decode
    import sfiq_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic [ADDR_W-1:2] word_addr,
    output reg_id_e           reg_id
);
    localparam int unsigned IDX_W = ADDR_W - 2;

    always_comb begin
        if (word_addr < IDX_W'(REG_COUNT)) begin
            reg_id = reg_id_e'(word_addr[5:2]);
        end else begin
            reg_id = RG_NONE;
        end
    end

endmodule

// File: rtl/sfiq_access.sv
module sfiq_access
    import sfiq_pkg::*;
(
    input  logic    psel,
    input  logic    penable,
    input  logic    pwrite,
    input  logic    ppriv,
    input  reg_id_e reg_id,
    input  logic    prot_q,
    input  logic    lock_q,
    output logic    wr_cfg_ok,
    output logic    wr_lock_ok,
    output logic    rd_ok
);
    logic priv_ok;
    logic wr_acc;

    always_comb begin
        priv_ok    = !prot_q || ppriv;
        wr_acc     = psel && penable && pwrite && priv_ok;
        wr_lock_ok = wr_acc && (reg_id == RG_LOCK);
        wr_cfg_ok  = wr_acc && !lock_q;
        rd_ok      = psel && !pwrite && priv_ok;
    end

endmodule

// File: rtl/sfiq_regs.sv
module sfiq_regs
    import sfiq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  reg_id_e           reg_id,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_cfg_ok,
    input  logic              wr_lock_ok,
    output cfg_t              cfg_q
);
    cfg_t cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_lock_ok) begin
            cfg_d.lock = (wdata != UNLOCK_KEY);
        end
        if (wr_cfg_ok) begin
            case (reg_id)
                RG_SEL:   cfg_d.sel  = wdata[SRC_N-1:0];
                RG_EN:    cfg_d.en   = wdata[SRC_N-1:0];
                RG_ENCLR: cfg_d.en   = cfg_q.en & ~wdata[SRC_N-1:0];
                RG_BYP:   cfg_d.byp  = wdata[0];
                RG_PROT:  cfg_d.prot = wdata[0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

endmodule

// File: rtl/sfiq_route.sv
module sfiq_route
    import sfiq_pkg::*;
(
    input  logic [SRC_N-1:0] src,
    input  cfg_t             cfg,
    input  logic             chain_n,
    input  logic             nsfiq_n,
    output logic [SRC_N-1:0] irq,
    output logic [SRC_N-1:0] fiq_stat,
    output logic             fiq_n
);
    for (genvar g = 0; g < SRC_N; g++) begin : g_src
        assign irq[g]      = src[g] & ~cfg.sel[g];
        assign fiq_stat[g] = src[g] & cfg.sel[g] & cfg.en[g];
    end

    logic secure_n;

    always_comb begin
        secure_n = !(|fiq_stat) && chain_n && nsfiq_n;
        fiq_n    = cfg.byp ? nsfiq_n : secure_n;
    end

endmodule

// File: rtl/secure_fiq_ctrl.sv
module secure_fiq_ctrl
    import sfiq_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    input  logic              ppriv,
    output logic [31:0]       prdata,
    input  logic [31:0]       src_i,
    input  logic              nsfiq_n_i,
    input  logic              chain_fiq_n_i,
    output logic [31:0]       irq_o,
    output logic              fiq_n_o
);
    reg_id_e          reg_id;
    cfg_t             cfg;
    logic             wr_cfg_ok;
    logic             wr_lock_ok;
    logic             rd_ok;
    logic [SRC_N-1:0] fiq_stat;
    wire              unused_addr_lsb = ^paddr[1:0];

    sfiq_decode #(.ADDR_W(ADDR_W)) i_decode (
        .word_addr (paddr[ADDR_W-1:2]),
        .reg_id    (reg_id)
    );

    sfiq_access i_access (
        .psel       (psel),
        .penable    (penable),
        .pwrite     (pwrite),
        .ppriv      (ppriv),
        .reg_id     (reg_id),
        .prot_q     (cfg.prot),
        .lock_q     (cfg.lock),
        .wr_cfg_ok  (wr_cfg_ok),
        .wr_lock_ok (wr_lock_ok),
        .rd_ok      (rd_ok)
    );

    sfiq_regs i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_id     (reg_id),
        .wdata      (pwdata),
        .wr_cfg_ok  (wr_cfg_ok),
        .wr_lock_ok (wr_lock_ok),
        .cfg_q      (cfg)
    );

    sfiq_route i_route (
        .src      (src_i),
        .cfg      (cfg),
        .chain_n  (chain_fiq_n_i),
        .nsfiq_n  (nsfiq_n_i),
        .irq      (irq_o),
        .fiq_stat (fiq_stat),
        .fiq_n    (fiq_n_o)
    );

    always_comb begin
        prdata = '0;
        if (rd_ok) begin
            case (reg_id)
                RG_FIQSTAT: prdata = DATA_W'(fiq_stat);
                RG_RAW:     prdata = DATA_W'(src_i);
                RG_SEL:     prdata = DATA_W'(cfg.sel);
                RG_EN:      prdata = DATA_W'(cfg.en);
                RG_BYP:     prdata = DATA_W'(cfg.byp);
                RG_PROT:    prdata = DATA_W'(cfg.prot);
                RG_LOCKST:  prdata = DATA_W'(cfg.lock);
                default:    prdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/sfiq_checker.sv
module sfiq_checker
    import sfiq_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input logic        clk,
    input logic        rst_n,
    input logic        psel,
    input logic        penable,
    input logic        pwrite,
    input logic        ppriv,
    input logic [31:0] pwdata,
    input logic [31:0] prdata,
    input logic        nsfiq_n_i,
    input logic        chain_fiq_n_i,
    input logic        fiq_n_o,
    input reg_id_e     reg_id,
    input cfg_t        cfg
);
    logic wr_phase;
    logic may_access;
    assign wr_phase   = psel && penable && pwrite;
    assign may_access = !cfg.prot || ppriv;

    AST_SEL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_phase && reg_id == RG_SEL && !cfg.lock && may_access)
        |=> cfg.sel == $past(pwdata[SRC_N-1:0])); // R4

    AST_EN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_phase && reg_id == RG_ENCLR && !cfg.lock && may_access)
        |=> cfg.en == ($past(cfg.en) & ~$past(pwdata[SRC_N-1:0]))); // R5

    AST_CHAIN_PULLS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.byp && (!chain_fiq_n_i || !nsfiq_n_i)) |-> !fiq_n_o); // R6

    AST_BYPASS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.byp |-> fiq_n_o == nsfiq_n_i); // R7

    AST_USER_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_phase && cfg.prot && !ppriv) |=> $stable(cfg)); // R8

    AST_USER_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !pwrite && cfg.prot && !ppriv) |-> prdata == '0); // R8

    AST_LOCK_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_phase && reg_id == RG_LOCK && may_access)
        |=> cfg.lock == ($past(pwdata) != UNLOCK_KEY)); // R9

    AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_phase && cfg.lock && reg_id != RG_LOCK) |=> $stable(cfg)); // R10

endmodule

bind secure_fiq_ctrl sfiq_checker #(.ADDR_W(ADDR_W)) i_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .psel          (psel),
    .penable       (penable),
    .pwrite        (pwrite),
    .ppriv         (ppriv),
    .pwdata        (pwdata),
    .prdata        (prdata),
    .nsfiq_n_i     (nsfiq_n_i),
    .chain_fiq_n_i (chain_fiq_n_i),
    .fiq_n_o       (fiq_n_o),
    .reg_id        (reg_id),
    .cfg           (cfg)
);

// File: tb/test_secure_fiq_ctrl.sv
`timescale 1ns/1ps
module test_secure_fiq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0, ppriv = 1'b1;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic [31:0] src_i = '0;
    logic        nsfiq_n_i = 1'b1, chain_fiq_n_i = 1'b1;
    logic [31:0] irq_o;
    logic        fiq_n_o;

    int nchk = 0;
    int nerr = 0;
    int cycles = 0;
    bit done = 1'b0;

    // reference state
    logic [31:0] m_sel = '0, m_en = '0;
    bit m_byp = 0, m_prot = 0, m_lock = 0;

    always #5 clk = ~clk;

    secure_fiq_ctrl i_secure_fiq_ctrl (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .ppriv(ppriv),
        .prdata(prdata), .src_i(src_i), .nsfiq_n_i(nsfiq_n_i),
        .chain_fiq_n_i(chain_fiq_n_i), .irq_o(irq_o), .fiq_n_o(fiq_n_o)
    );

    function automatic logic [31:0] exp_irq();
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = m_sel[i] ? 1'b0 : src_i[i];
        return r;
    endfunction

    function automatic logic [31:0] exp_stat();
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = src_i[i] && m_sel[i] && m_en[i];
        return r;
    endfunction

    function automatic logic exp_fiq_n();
        if (m_byp) return nsfiq_n_i;
        if (exp_stat() != 0) return 1'b0;
        if (chain_fiq_n_i == 1'b0 || nsfiq_n_i == 1'b0) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic [31:0] exp_read(input logic [11:0] a, input bit priv);
        if (m_prot && !priv) return 32'h0;
        case (a)
            12'h000: return exp_stat();
            12'h004: return src_i;
            12'h008: return m_sel;
            12'h00C: return m_en;
            12'h014: return {31'h0, m_byp};
            12'h018: return {31'h0, m_prot};
            12'h020: return {31'h0, m_lock};
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_write(input logic [11:0] a, input logic [31:0] d, input bit priv);
        if (m_prot && !priv) return;
        if (a == 12'h01C) begin
            m_lock = (d != 32'h0ACC_E550);
            return;
        end
        if (m_lock) return;
        case (a)
            12'h008: m_sel = d;
            12'h00C: m_en = d;
            12'h010: m_en = m_en & ~d;
            12'h014: m_byp = d[0];
            12'h018: m_prot = d[0];
            default: ;
        endcase
    endtask

    // per-cycle comparison of the combinational outputs
    always @(posedge clk) begin
        #3;
        if (rst_n && !done) begin
            nchk++;
            if (irq_o !== exp_irq()) begin
                nerr++;
                $display("FAIL R2 irq_o actual %h expected %h", irq_o, exp_irq());
            end
            nchk++;
            if (fiq_n_o !== exp_fiq_n()) begin
                nerr++;
                $display("FAIL R6/R7 fiq_n_o actual %b expected %b", fiq_n_o, exp_fiq_n());
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            nerr++;
            $display("FAIL R1 watchdog: cycles actual %0d expected below 20000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
            $finish;
        end
    end

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d, input bit priv);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d; ppriv = priv;
        @(negedge clk);
        penable = 1'b1;
        @(posedge clk);
        #1 model_write(a, d, priv);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0; ppriv = 1'b1;
    endtask

    task automatic bus_read(input logic [11:0] a, input bit priv, input string req);
        logic [31:0] e;
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a; ppriv = priv;
        @(negedge clk);
        penable = 1'b1;
        #1;
        e = exp_read(a, priv);
        nchk++;
        if (prdata !== e) begin
            nerr++;
            $display("FAIL %s read %h actual %h expected %h", req, a, prdata, e);
        end
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; ppriv = 1'b1;
    endtask

    task automatic set_lines(input logic [31:0] s, input logic ns, input logic ch);
        @(negedge clk);
        src_i = s; nsfiq_n_i = ns; chain_fiq_n_i = ch;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        for (int a = 0; a <= 12'h020; a += 4) bus_read(12'(a), 1'b1, "R1");
        set_lines(32'hA5A5_0F0F, 1'b1, 1'b1);
        set_lines(32'hFFFF_FFFF, 1'b1, 1'b1);

        // R4 and R2: select register
        bus_write(12'h008, 32'h0000_FFFF, 1'b1);
        bus_read(12'h008, 1'b1, "R4");
        set_lines(32'h1234_5678, 1'b1, 1'b1);
        bus_read(12'h004, 1'b1, "R3");

        // R3 and R6: enable routes selected sources to FIQ
        bus_write(12'h00C, 32'h0000_00F3, 1'b1);
        bus_read(12'h00C, 1'b1, "R4");
        bus_read(12'h000, 1'b1, "R3");
        set_lines(32'hFFFF_0000, 1'b1, 1'b1);
        bus_read(12'h000, 1'b1, "R3");
        set_lines(32'h0000_0002, 1'b1, 1'b1);

        // R5: enable clear
        bus_write(12'h010, 32'h0000_0003, 1'b1);
        bus_read(12'h00C, 1'b1, "R5");
        bus_read(12'h010, 1'b1, "R5");
        bus_write(12'h010, 32'h0000_0000, 1'b1);
        bus_read(12'h00C, 1'b1, "R5");

        // R6: chain and non-secure FIQ inputs
        set_lines(32'h0, 1'b1, 1'b0);
        set_lines(32'h0, 1'b0, 1'b1);
        set_lines(32'h0, 1'b1, 1'b1);

        // R7: bypass
        bus_write(12'h014, 32'hFFFF_FFFF, 1'b1);
        bus_read(12'h014, 1'b1, "R7");
        set_lines(32'h0000_00F0, 1'b1, 1'b0);
        set_lines(32'h0000_00F0, 1'b0, 1'b0);
        bus_write(12'h014, 32'h0000_0000, 1'b1);
        set_lines(32'h0000_00F0, 1'b1, 1'b1);

        // R8: protection
        bus_write(12'h018, 32'h0000_0001, 1'b1);
        bus_write(12'h008, 32'hFFFF_FFFF, 1'b0);
        bus_read(12'h008, 1'b0, "R8");
        bus_read(12'h008, 1'b1, "R8");
        bus_write(12'h01C, 32'h1111_2222, 1'b0);
        bus_read(12'h020, 1'b1, "R8");
        bus_write(12'h008, 32'h00FF_00FF, 1'b1);
        bus_read(12'h008, 1'b1, "R8");
        bus_write(12'h018, 32'h0000_0000, 1'b1);
        bus_read(12'h018, 1'b0, "R8");

        // R9 and R10: lock
        bus_write(12'h01C, 32'hDEAD_BEEF, 1'b1);
        bus_read(12'h020, 1'b1, "R9");
        bus_read(12'h01C, 1'b1, "R9");
        bus_write(12'h008, 32'h0F0F_0F0F, 1'b1);
        bus_write(12'h010, 32'hFFFF_FFFF, 1'b1);
        bus_write(12'h014, 32'h0000_0001, 1'b1);
        bus_write(12'h018, 32'h0000_0001, 1'b1);
        bus_read(12'h008, 1'b1, "R10");
        bus_read(12'h00C, 1'b1, "R10");
        bus_read(12'h014, 1'b1, "R10");
        bus_read(12'h018, 1'b1, "R10");
        bus_write(12'h01C, 32'h0ACC_E551, 1'b1);
        bus_read(12'h020, 1'b1, "R9");
        bus_write(12'h01C, 32'h0ACC_E550, 1'b1);
        bus_read(12'h020, 1'b1, "R9");
        bus_write(12'h008, 32'h0F0F_0F0F, 1'b1);
        bus_read(12'h008, 1'b1, "R10");

        // R11: unmapped and read-only addresses
        bus_write(12'h024, 32'hFFFF_FFFF, 1'b1);
        bus_write(12'h100, 32'hFFFF_FFFF, 1'b1);
        bus_write(12'h000, 32'hFFFF_FFFF, 1'b1);
        bus_write(12'h020, 32'hFFFF_FFFF, 1'b1);
        bus_read(12'h024, 1'b1, "R11");
        bus_read(12'hFFC, 1'b1, "R11");
        bus_read(12'h008, 1'b1, "R11");
        bus_read(12'h00C, 1'b1, "R11");
        bus_read(12'h020, 1'b1, "R11");
        set_lines(32'hFFFF_FFFF, 1'b1, 1'b1);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end

endmodule